// File: doc/BRIEF.md
# Timer Output Compare Unit

This unit compares the count of an external free-running timer against a primary compare value and a secondary compare value. From those matches it drives one output pin. A 3-bit mode, latched by a write strobe, chooses the pin behaviour:

- idle
- one-shot set or clear on the primary match
- toggle on each primary match
- a single delayed pulse
- a pulse that repeats every timer period
- pulse-width modulation, either with or without a fault shutdown

Each pin transition that the selected mode qualifies raises a one-cycle compare event. In the fault-protected PWM mode, a falling edge on the active-low fault input latches a fault flag and holds the pin low.

The surrounding logic owns the timer, the register access and the pin routing. The mode should be rewritten only while the timer is stopped, and a mode change while the timer runs gives no defined pin sequence. In the PWM modes the duty value is double-buffered. The secondary value is taken into the active duty register only at the timer period-match strobe, so a new duty takes effect from the next period.

Top module: `oc_unit`

## Requirements
- R1: After reset the pin, compare event and fault flag are all 0. A mode write sets the pin, on the next clock edge, to 0 for modes 3'b001, 3'b100 and 3'b101, and to 1 for mode 3'b010. For modes 3'b110 and 3'b111 it sets the pin to 1 when the primary value is non-zero and to 0 when it is zero.
- R2: A mode write of 3'b000 or 3'b011 keeps the present pin level. In mode 3'b000 the pin holds its level whatever the timer does.
- R3: In mode 3'b001 the pin goes to 1 at the edge where the timer equals the primary value. It then stays 1 until the next mode write, and the rising transition raises a compare event.
- R4: In mode 3'b010 the pin goes to 0 at the primary match and stays 0, and the falling transition raises a compare event.
- R5: In mode 3'b011 the pin inverts at every primary match, and each inversion raises a compare event.
- R6: In mode 3'b100 the pin goes to 1 at the primary match and returns to 0 at the secondary match. After that it stays 0 until the next mode write, and only the falling transition raises a compare event.
- R7: In mode 3'b101 the rise at the primary match and the fall at the secondary match repeat every period, and each fall raises a compare event.
- R8: In modes 3'b110 and 3'b111 the pin goes to 1 on the period-match strobe and to 0 when the timer equals the active duty value. These modes raise no compare event.
- R9: The active duty value is loaded from the primary value on the mode write, and after that from the secondary value only on the period-match strobe. A secondary change mid-period leaves the current period unchanged.
- R10: In mode 3'b111 a high-to-low transition on the fault input sets the fault flag and drives the pin to 0. Both stay that way until the next mode write, which clears the flag. In every other mode the fault input has no effect on the pin or the flag.
- R11: The compare event is a single-cycle pulse in the same cycle as the pin transition it reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_cnt | input | TMR_W | Current timer count |
| tmr_period_hit | input | 1 | Timer period-match strobe |
| cmp_pri | input | TMR_W | Primary compare value |
| cmp_sec | input | TMR_W | Secondary compare value |
| mode_sel | input | 3 | Mode to load |
| mode_wr | input | 1 | Mode write strobe |
| fault_n | input | 1 | Active-low fault input |
| oc_pin | output | 1 | Compare output pin level |
| cmp_irq | output | 1 | One-cycle compare event |
| fault_flag | output | 1 | Latched fault flag |

## Verification
The bench builds the unit with an 8-bit timer width. With that width, small counts and period points are short to write, and a zero primary value, the edge case for the PWM start level, can be set. A single vector table walks through every mode in turn. The rows include a duty change during a period, a repeated match after a one-shot has completed, and a fault edge both with and without fault protection. Directed steps then cover the reset state and the level-keeping mode entries with the pin high.

// File: rtl/oc_pkg.sv
// Package: mode encoding and per-mode policies of the output compare unit.
// Assumes a 3-bit mode code whose values are fixed by the surrounding software.
package oc_pkg;

    typedef enum logic [2:0] {
        OC_OFF      = 3'b000,
        OC_SHOT_HI  = 3'b001,
        OC_SHOT_LO  = 3'b010,
        OC_TOGGLE   = 3'b011,
        OC_SHOT_DLY = 3'b100,
        OC_PULSE    = 3'b101,
        OC_PWM      = 3'b110,
        OC_PWM_FLT  = 3'b111
    } oc_mode_e;

    // Pin level applied when a mode is written.
    function automatic logic oc_entry_level(oc_mode_e m, logic cur, logic pri_nz);
        case (m)
            OC_SHOT_LO:         return 1'b1;
            OC_PWM, OC_PWM_FLT: return pri_nz;
            OC_OFF, OC_TOGGLE:  return cur;
            default:            return 1'b0;
        endcase
    endfunction

    // Whether a pin transition raises a compare event in the given mode.
    function automatic logic oc_edge_event(oc_mode_e m, logic rise, logic fall);
        case (m)
            OC_SHOT_HI:                        return rise;
            OC_SHOT_LO, OC_SHOT_DLY, OC_PULSE: return fall;
            OC_TOGGLE:                         return rise | fall;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/oc_match.sv
// Comparator stage: equality of the timer against the primary, secondary and
// active duty values. Also holds the double-buffered active duty register.
// Assumes the period strobe is high in the cycle the timer reaches its period.
module oc_match #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] tmr_cnt,
    input  logic             period_hit,
    input  logic [TMR_W-1:0] cmp_pri,
    input  logic [TMR_W-1:0] cmp_sec,
    input  logic             mode_wr,
    output logic             hit_pri,
    output logic             hit_sec,
    output logic             hit_duty,
    output logic             pri_nz
);

    logic [TMR_W-1:0] duty_q;

    // Active duty: primary on mode write, secondary at period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          duty_q <= '0;
        else if (mode_wr)    duty_q <= cmp_pri;
        else if (period_hit) duty_q <= cmp_sec;
    end

    // Equality compares against the live count.
    always_comb begin
        hit_pri  = (tmr_cnt == cmp_pri);
        hit_sec  = (tmr_cnt == cmp_sec);
        hit_duty = (tmr_cnt == duty_q);
        pri_nz   = |cmp_pri;
    end

    // R9: duty only moves on a write or a period boundary
    assert_duty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_hit && !mode_wr) |=> $stable(duty_q));

endmodule

// File: rtl/oc_fault.sv
// Fault stage: detects a high-to-low edge on the active-low fault input while
// the fault-protected PWM mode is active, and latches it until a mode write.
module oc_fault
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fault_n,
    input  logic     mode_wr,
    input  oc_mode_e mode_q,
    output logic     trip,
    output logic     latched
);

    logic fault_n_q;
    logic flag_q;

    // Delay the fault input by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_n_q <= 1'b1;
        else        fault_n_q <= fault_n;
    end

    // A fault edge counts only in the protected PWM mode and outside writes.
    always_comb begin
        trip = fault_n_q && !fault_n && !mode_wr && (mode_q == OC_PWM_FLT);
    end

    // Sticky flag, cleared by any mode write.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (mode_wr) flag_q <= 1'b0;
        else if (trip)    flag_q <= 1'b1;
    end

    assign latched = flag_q;

    // R10: the flag persists until a mode write
    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !mode_wr) |=> flag_q);

endmodule

// File: rtl/oc_pin.sv
// Pin sequencer: holds the mode, the pin level and the one-shot completion
// state. Drives the pin from the match strobes and raises qualified edge events.
// Assumes the mode is written only while the timer is stopped.
module oc_pin
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_sel,
    input  logic       period_hit,
    input  logic       hit_pri,
    input  logic       hit_sec,
    input  logic       hit_duty,
    input  logic       pri_nz,
    input  logic       fault_force,
    output oc_mode_e   mode_q,
    output logic       pin_q,
    output logic       irq_q
);

    logic pin_d;
    logic done_q;
    logic done_d;

    // Next pin level and completion state per mode.
    always_comb begin
        pin_d  = pin_q;
        done_d = done_q;
        case (mode_q)
            OC_SHOT_HI:  if (!done_q && hit_pri) begin pin_d = 1'b1; done_d = 1'b1; end
            OC_SHOT_LO:  if (!done_q && hit_pri) begin pin_d = 1'b0; done_d = 1'b1; end
            OC_TOGGLE:   if (hit_pri) pin_d = ~pin_q;
            OC_SHOT_DLY: begin
                if (!done_q) begin
                    if (!pin_q && hit_pri)     pin_d = 1'b1;
                    else if (pin_q && hit_sec) begin pin_d = 1'b0; done_d = 1'b1; end
                end
            end
            OC_PULSE: begin
                if (!pin_q && hit_pri)      pin_d = 1'b1;
                else if (pin_q && hit_sec)  pin_d = 1'b0;
            end
            OC_PWM, OC_PWM_FLT: begin
                if (period_hit)    pin_d = 1'b1;
                else if (hit_duty) pin_d = 1'b0;
            end
            default: ;
        endcase
        if (mode_q == OC_PWM_FLT && fault_force) pin_d = 1'b0;
    end

    // State update; a mode write takes precedence over matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OC_OFF;
            pin_q  <= 1'b0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (mode_wr) begin
            mode_q <= oc_mode_e'(mode_sel);
            pin_q  <= oc_entry_level(oc_mode_e'(mode_sel), pin_q, pri_nz);
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            pin_q  <= pin_d;
            done_q <= done_d;
            irq_q  <= oc_edge_event(mode_q, pin_d & ~pin_q, ~pin_d & pin_q);
        end
    end

    // R2: idle mode freezes the pin
    assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OC_OFF && !mode_wr) |=> $stable(pin_q));
    // R3: a completed set-high one-shot stays high
    assert_shot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OC_SHOT_HI && pin_q && !mode_wr) |=> pin_q);
    // R8: idle and PWM modes are silent
    assert_pwm_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == OC_OFF || mode_q == OC_PWM || mode_q == OC_PWM_FLT) && !mode_wr) |=> !irq_q);
    // R11: an event always accompanies a pin transition
    assert_irq_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (pin_q != $past(pin_q)));

endmodule

// File: rtl/oc_unit.sv
// Top of the timer output compare unit: ties the comparator stage, the fault
// stage and the pin sequencer together. The timer and the register access lie outside.
module oc_unit
    import oc_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] tmr_cnt,
    input  logic             tmr_period_hit,
    input  logic [TMR_W-1:0] cmp_pri,
    input  logic [TMR_W-1:0] cmp_sec,
    input  logic [2:0]       mode_sel,
    input  logic             mode_wr,
    input  logic             fault_n,
    output logic             oc_pin,
    output logic             cmp_irq,
    output logic             fault_flag
);

    logic     hit_pri, hit_sec, hit_duty, pri_nz;
    logic     trip, latched;
    oc_mode_e mode_q;

    oc_match #(.TMR_W(TMR_W)) i_match (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .period_hit(tmr_period_hit),
        .cmp_pri(cmp_pri), .cmp_sec(cmp_sec), .mode_wr(mode_wr),
        .hit_pri(hit_pri), .hit_sec(hit_sec), .hit_duty(hit_duty), .pri_nz(pri_nz)
    );

    oc_fault i_fault (
        .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .mode_wr(mode_wr),
        .mode_q(mode_q), .trip(trip), .latched(latched)
    );

    oc_pin i_pin (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .period_hit(tmr_period_hit), .hit_pri(hit_pri), .hit_sec(hit_sec),
        .hit_duty(hit_duty), .pri_nz(pri_nz), .fault_force(trip | latched),
        .mode_q(mode_q), .pin_q(oc_pin), .irq_q(cmp_irq)
    );

    assign fault_flag = latched;

    // R10: while the fault flag is set the pin is low
    assert_fault_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> !oc_pin);

endmodule

// File: tb/test_oc_unit.sv
// Bench: vector table through all modes, then directed reset and hold cases.
module test_oc_unit;

    localparam int  TW       = 8;
    localparam time CLK_HALF = 5ns;

    typedef struct packed {
        logic          wr;
        logic [2:0]    md;
        logic [TW-1:0] tm;
        logic          pm;
        logic [TW-1:0] pr;
        logic [TW-1:0] sc;
        logic          fn;
        logic          e_pin;
        logic          e_irq;
        logic          e_flt;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VEC [NV] = '{
        '{1'b1,3'b001,8'd0,1'b0,8'd5,8'd9,1'b1,1'b0,1'b0,1'b0,4'd1}, // R1 one-shot high entry
        '{1'b0,3'b001,8'd4,1'b0,8'd5,8'd9,1'b1,1'b0,1'b0,1'b0,4'd3},
        '{1'b0,3'b001,8'd5,1'b0,8'd5,8'd9,1'b1,1'b1,1'b1,1'b0,4'd3}, // R3 rise with event
        '{1'b0,3'b001,8'd6,1'b0,8'd5,8'd9,1'b1,1'b1,1'b0,1'b0,4'd11},// R11 single pulse
        '{1'b0,3'b001,8'd5,1'b0,8'd5,8'd9,1'b1,1'b1,1'b0,1'b0,4'd3}, // R3 stays set
        '{1'b1,3'b010,8'd0,1'b0,8'd5,8'd9,1'b1,1'b1,1'b0,1'b0,4'd1}, // R1 one-shot low entry
        '{1'b0,3'b010,8'd5,1'b0,8'd5,8'd9,1'b1,1'b0,1'b1,1'b0,4'd4}, // R4 fall with event
        '{1'b0,3'b010,8'd5,1'b0,8'd5,8'd9,1'b1,1'b0,1'b0,1'b0,4'd4},
        '{1'b1,3'b011,8'd0,1'b0,8'd5,8'd9,1'b1,1'b0,1'b0,1'b0,4'd2}, // R2 toggle keeps level
        '{1'b0,3'b011,8'd5,1'b0,8'd5,8'd9,1'b1,1'b1,1'b1,1'b0,4'd5}, // R5
        '{1'b0,3'b011,8'd6,1'b0,8'd5,8'd9,1'b1,1'b1,1'b0,1'b0,4'd5},
        '{1'b0,3'b011,8'd5,1'b0,8'd5,8'd9,1'b1,1'b0,1'b1,1'b0,4'd5}, // R5 fall also signals
        '{1'b1,3'b100,8'd0,1'b0,8'd5,8'd9,1'b1,1'b0,1'b0,1'b0,4'd1},
        '{1'b0,3'b100,8'd5,1'b0,8'd5,8'd9,1'b1,1'b1,1'b0,1'b0,4'd6}, // R6 rise silent
        '{1'b0,3'b100,8'd9,1'b0,8'd5,8'd9,1'b1,1'b0,1'b1,1'b0,4'd6}, // R6 fall signals
        '{1'b0,3'b100,8'd5,1'b0,8'd5,8'd9,1'b1,1'b0,1'b0,1'b0,4'd6}, // R6 completed
        '{1'b1,3'b101,8'd0,1'b0,8'd5,8'd9,1'b1,1'b0,1'b0,1'b0,4'd1},
        '{1'b0,3'b101,8'd5,1'b0,8'd5,8'd9,1'b1,1'b1,1'b0,1'b0,4'd7}, // R7
        '{1'b0,3'b101,8'd9,1'b0,8'd5,8'd9,1'b1,1'b0,1'b1,1'b0,4'd7},
        '{1'b0,3'b101,8'd5,1'b0,8'd5,8'd9,1'b1,1'b1,1'b0,1'b0,4'd7}, // R7 repeats
        '{1'b0,3'b101,8'd9,1'b0,8'd5,8'd9,1'b1,1'b0,1'b1,1'b0,4'd7},
        '{1'b1,3'b110,8'd0,1'b0,8'd5,8'd3,1'b1,1'b1,1'b0,1'b0,4'd1}, // R1 PWM with nonzero primary
        '{1'b0,3'b110,8'd4,1'b0,8'd5,8'd3,1'b1,1'b1,1'b0,1'b0,4'd9}, // R9 duty from primary
        '{1'b0,3'b110,8'd5,1'b0,8'd5,8'd3,1'b1,1'b0,1'b0,1'b0,4'd8}, // R8 low at duty, silent
        '{1'b0,3'b110,8'd9,1'b1,8'd5,8'd3,1'b1,1'b1,1'b0,1'b0,4'd8}, // R8 high at period
        '{1'b0,3'b110,8'd2,1'b0,8'd5,8'd7,1'b1,1'b1,1'b0,1'b0,4'd9}, // R9 new secondary waits
        '{1'b0,3'b110,8'd3,1'b0,8'd5,8'd7,1'b1,1'b0,1'b0,1'b0,4'd9},
        '{1'b0,3'b110,8'd9,1'b1,8'd5,8'd7,1'b1,1'b1,1'b0,1'b0,4'd9},
        '{1'b0,3'b110,8'd3,1'b0,8'd5,8'd7,1'b1,1'b1,1'b0,1'b0,4'd9}, // R9 new duty in force
        '{1'b0,3'b110,8'd7,1'b0,8'd5,8'd7,1'b1,1'b0,1'b0,1'b0,4'd9},
        '{1'b0,3'b110,8'd9,1'b1,8'd5,8'd7,1'b1,1'b1,1'b0,1'b0,4'd8},
        '{1'b0,3'b110,8'd2,1'b0,8'd5,8'd7,1'b0,1'b1,1'b0,1'b0,4'd10},// R10 fault ignored
        '{1'b1,3'b111,8'd0,1'b0,8'd0,8'd4,1'b1,1'b0,1'b0,1'b0,4'd1}, // R1 zero primary
        '{1'b0,3'b111,8'd9,1'b1,8'd0,8'd4,1'b1,1'b1,1'b0,1'b0,4'd8},
        '{1'b0,3'b111,8'd2,1'b0,8'd0,8'd4,1'b0,1'b0,1'b0,1'b1,4'd10},// R10 fault trips
        '{1'b0,3'b111,8'd9,1'b1,8'd0,8'd4,1'b1,1'b0,1'b0,1'b1,4'd10},// R10 held low
        '{1'b0,3'b111,8'd4,1'b0,8'd0,8'd4,1'b1,1'b0,1'b0,1'b1,4'd10},
        '{1'b1,3'b000,8'd0,1'b0,8'd5,8'd4,1'b1,1'b0,1'b0,1'b0,4'd10} // R10 write clears flag
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tmr_cnt = '0;
    logic          tmr_period_hit = 1'b0;
    logic [TW-1:0] cmp_pri = '0;
    logic [TW-1:0] cmp_sec = '0;
    logic [2:0]    mode_sel = '0;
    logic          mode_wr = 1'b0;
    logic          fault_n = 1'b1;
    logic          oc_pin, cmp_irq, fault_flag;
    int            n_run = 0;
    int            n_fail = 0;

    oc_unit #(.TMR_W(TW)) i_oc_unit (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_period_hit(tmr_period_hit),
        .cmp_pri(cmp_pri), .cmp_sec(cmp_sec), .mode_sel(mode_sel), .mode_wr(mode_wr),
        .fault_n(fault_n), .oc_pin(oc_pin), .cmp_irq(cmp_irq), .fault_flag(fault_flag)
    );

    always #(CLK_HALF) clk = ~clk;

    task automatic chk(input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [2:0] md, input logic [TW-1:0] tm,
                         input logic pm, input logic [TW-1:0] pr, input logic [TW-1:0] sc,
                         input logic fn);
        mode_wr = wr; mode_sel = md; tmr_cnt = tm; tmr_period_hit = pm;
        cmp_pri = pr; cmp_sec = sc; fault_n = fn;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset pin", oc_pin, 1'b0);
        chk("R1 reset irq", cmp_irq, 1'b0);
        chk("R1 reset fault", fault_flag, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wr, VEC[i].md, VEC[i].tm, VEC[i].pm, VEC[i].pr, VEC[i].sc, VEC[i].fn);
            chk($sformatf("R%0d row %0d pin", VEC[i].rq, i), oc_pin, VEC[i].e_pin);
            chk($sformatf("R%0d row %0d irq", VEC[i].rq, i), cmp_irq, VEC[i].e_irq);
            chk($sformatf("R%0d row %0d fault", VEC[i].rq, i), fault_flag, VEC[i].e_flt);
        end

        // R2: idle and toggle entries keep a high pin
        drive(1'b1, 3'b010, 8'd0, 1'b0, 8'd5, 8'd9, 1'b1);
        chk("R2 setup high", oc_pin, 1'b1);
        drive(1'b1, 3'b000, 8'd0, 1'b0, 8'd5, 8'd9, 1'b1);
        chk("R2 idle entry keeps high", oc_pin, 1'b1);
        drive(1'b0, 3'b000, 8'd5, 1'b1, 8'd5, 8'd5, 1'b0);
        chk("R2 idle ignores matches", oc_pin, 1'b1);
        chk("R2 idle no event", cmp_irq, 1'b0);
        chk("R10 idle ignores fault", fault_flag, 1'b0);
        drive(1'b1, 3'b011, 8'd0, 1'b0, 8'd5, 8'd9, 1'b1);
        chk("R2 toggle entry keeps high", oc_pin, 1'b1);
        // R1: protected PWM with nonzero primary starts high
        drive(1'b1, 3'b111, 8'd0, 1'b0, 8'd6, 8'd9, 1'b1);
        chk("R1 pwm entry high", oc_pin, 1'b1);
        // R1: reset in mid-operation returns to idle low
        rst_n = 1'b0;
        drive(1'b0, 3'b000, 8'd0, 1'b0, 8'd0, 8'd0, 1'b1);
        chk("R1 reset again pin", oc_pin, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule